// File: doc/BRIEF.md
# VLIW Writeback Slot Hazard Checker

This block sits in front of the issue stage of a multi-slot VLIW core. Each cycle it sees a proposed bundle: one valid bit and one functional-unit type code per issue slot. Every unit type has a fixed latency. A result from that unit reaches the register file exactly that many cycles after issue. The checker keeps a forward booking of how many register writes are already promised for each future cycle. It accepts the bundle only if adding the bundle's writebacks keeps every future cycle at or below the write-port cap, and only if every targeted unit is free.

All functional units take a new operation every cycle, except the iterative square-root/divide unit, which stays busy for a parameterised number of cycles after each issue. An accepted bundle adds all of its writebacks to the booking in one step. A stalled bundle adds nothing. The count of writes landing in the current cycle is brought out so that the register-file write arbiter can size its ports.

Top module: `wb_slot_guard`

## Requirements
- R1: `accept` is high when at least one slot is valid and the bundle passes every check. `stall` is high when at least one slot is valid and the bundle fails a check. Both are low for an empty bundle, and the two are never high together.
- R2: Unit codes map to writeback latencies as follows. Code 2 (packed-lane ALU) takes 2 cycles. Codes 3, 4, 5, 7, 8 and 9 (packed multiply, load/store, cache control, branch, float arithmetic, integer/float multiply) take 3 cycles. Code 11 (iterative sqrt/divide) takes DIV_LAT cycles, default 17. All other codes (0 constant, 1 ALU, 6 shifter, 10 float compare, 12 to 15 spare) take 1 cycle. An operation accepted in cycle t is counted in `wb_count` in cycle t+latency.
- R3: A bundle is stalled if accepting it would make any future cycle hold more than WB_MAX (default 5) register writes.
- R4: After an operation of code 11 is accepted in cycle t, another code-11 operation is stalled until cycle t+DIV_REC (default 17), and it may be accepted from that cycle on.
- R5: A bundle with two or more valid code-11 slots is always stalled.
- R6: A stalled bundle changes neither the writeback booking nor the busy state of the divide unit.
- R7: `wb_count` reports the number of accepted operations whose writeback falls in the current cycle, and it never exceeds WB_MAX.
- R8: After reset, `wb_count` is 0, nothing is booked, and the divide unit is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_vld | input | NSLOT | Per-slot valid bits of the proposed bundle |
| slot_unit | input | NSLOT*TW | Per-slot unit type code; slot s uses bits [s*TW +: TW] |
| accept | output | 1 | Bundle issues this cycle |
| stall | output | 1 | Bundle is held back this cycle |
| wb_count | output | $clog2(WB_MAX+1) | Register writes landing in this cycle |

## Verification
The two checks that most often collide are the write-cap check and the divide-unit busy check. A single bundle can fail both at once. A long-latency divide can also book a cycle that a later burst of short operations then tries to fill. The bench provokes this with a directed run that fills one future cycle to the cap while the divide unit is busy, and with a long random run weighted toward code 11 and full bundles. Each cycle it compares `accept`, `stall` and `wb_count` against a behavioural scoreboard, which keeps per-cycle write totals and the next cycle at which the divide unit is free.

// File: rtl/wb_slot_guard.sv
module wb_slot_guard #(
  parameter int NSLOT    = 5,
  parameter int TW       = 4,
  parameter int WB_MAX   = 5,
  parameter int DIV_LAT  = 17,
  parameter int DIV_REC  = 17,
  parameter int DIV_CODE = 11
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NSLOT-1:0]              slot_vld,
  input  logic [NSLOT*TW-1:0]           slot_unit,
  output logic                          accept,
  output logic                          stall,
  output logic [$clog2(WB_MAX+1)-1:0]   wb_count
);
  localparam int MAXLAT = (DIV_LAT > 3) ? DIV_LAT : 3;
  localparam int D      = MAXLAT + 1;
  localparam int CW     = $clog2(WB_MAX + 1);
  localparam int SW     = $clog2(WB_MAX + NSLOT + 1);
  localparam int RW     = $clog2(DIV_REC + 1);
  localparam int NW     = $clog2(NSLOT + 1);

  function automatic int lat_of(input logic [TW-1:0] u);
    case (int'(u))
      2:                 return 2;
      3, 4, 5, 7, 8, 9:  return 3;
      DIV_CODE:          return DIV_LAT;
      default:           return 1;
    endcase
  endfunction

  logic [CW-1:0] book [D];
  logic [SW-1:0] add  [D];
  logic [RW-1:0] div_busy;
  logic [NW-1:0] ndiv;
  logic          cap_ok, div_ok, any_vld;

  always_comb begin
    for (int i = 0; i < D; i++) add[i] = '0;
    ndiv = '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (slot_vld[s]) begin
        add[lat_of(slot_unit[s*TW +: TW])] += SW'(1);
        if (int'(slot_unit[s*TW +: TW]) == DIV_CODE) ndiv += NW'(1);
      end
    end
  end

  always_comb begin
    cap_ok = 1'b1;
    for (int i = 1; i < D; i++)
      if (int'(SW'(book[i]) + add[i]) > WB_MAX) cap_ok = 1'b0;
  end

  assign div_ok   = (ndiv == '0) || (ndiv == NW'(1) && div_busy == '0);
  assign any_vld  = |slot_vld;
  assign accept   = any_vld && cap_ok && div_ok;
  assign stall    = any_vld && !(cap_ok && div_ok);
  assign wb_count = book[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < D; i++) book[i] <= '0;
      div_busy <= '0;
    end else begin
      for (int i = 0; i < D - 1; i++)
        book[i] <= accept ? CW'(SW'(book[i+1]) + add[i+1]) : book[i+1];
      book[D-1] <= '0;
      if (accept && ndiv != '0) div_busy <= RW'(DIV_REC - 1);
      else if (div_busy != '0)  div_busy <= div_busy - RW'(1);
    end
  end

  logic lat1_acc, div_acc;
  assign lat1_acc = accept && add[1] != '0;
  assign div_acc  = accept && ndiv != '0;

  p_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && stall));
  p_lat1_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lat1_acc |=> wb_count != '0);
  p_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(wb_count) <= WB_MAX);
  p_div_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    div_acc |=> !div_acc);
  p_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ndiv > NW'(1)) |-> !accept);
  p_nobook_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> wb_count == $past(book[1]));
endmodule

// File: tb/sim_wb_slot_guard.sv
module sim_wb_slot_guard;
  localparam int NSLOT = 5, TW = 4, WB_MAX = 5, DIV_LAT = 17, DIV_REC = 17;
  localparam int RING = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NSLOT-1:0] slot_vld = '0;
  logic [NSLOT*TW-1:0] slot_unit = '0;
  logic accept, stall;
  logic [2:0] wb_count;

  always #5 clk = ~clk;

  wb_slot_guard #(.NSLOT(NSLOT), .TW(TW), .WB_MAX(WB_MAX),
                  .DIV_LAT(DIV_LAT), .DIV_REC(DIV_REC), .DIV_CODE(11)) u0 (
    .clk(clk), .rst_n(rst_n), .slot_vld(slot_vld), .slot_unit(slot_unit),
    .accept(accept), .stall(stall), .wb_count(wb_count));

  int n_chk = 0, n_bad = 0;
  int book [RING];
  int cyc = 0;
  int div_free_at = 0;
  int n_acc_div = 0;

  function automatic int ref_lat(int u);
    if (u == 2) return 2;
    if (u == 3 || u == 4 || u == 5 || u == 7 || u == 8 || u == 9) return 3;
    if (u == 11) return DIV_LAT;
    return 1;
  endfunction

  task automatic chk(string tag, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic step(string tag, logic [NSLOT-1:0] v, int u0_, int u1_, int u2_, int u3_, int u4_);
    int us [NSLOT];
    int tmp [RING];
    int nd, anyv, ok, e_acc;
    us[0] = u0_; us[1] = u1_; us[2] = u2_; us[3] = u3_; us[4] = u4_;
    @(negedge clk);
    slot_vld = v;
    for (int s = 0; s < NSLOT; s++) slot_unit[s*TW +: TW] = TW'(us[s]);
    #1;
    for (int i = 0; i < RING; i++) tmp[i] = 0;
    nd = 0; anyv = 0;
    for (int s = 0; s < NSLOT; s++) if (v[s]) begin
      anyv = 1;
      tmp[(cyc + ref_lat(us[s])) % RING]++;
      if (us[s] == 11) nd++;
    end
    ok = 1;
    for (int i = 0; i < RING; i++) if (book[i] + tmp[i] > WB_MAX) ok = 0;
    if (nd > 1) ok = 0;
    if (nd == 1 && cyc < div_free_at) ok = 0;
    e_acc = anyv && ok;
    chk(tag, int'(accept), e_acc, "accept");
    chk(tag, int'(stall), anyv && !ok, "stall");
    chk("R7", int'(wb_count), book[cyc % RING], "wb_count");
    @(posedge clk);
    if (e_acc) begin
      for (int i = 0; i < RING; i++) book[i] += tmp[i];
      if (nd == 1) begin div_free_at = cyc + DIV_REC; n_acc_div++; end
    end
    book[cyc % RING] = 0;
    cyc++;
  endtask

  task automatic idle(string tag, int n);
    for (int k = 0; k < n; k++) step(tag, '0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < RING; i++) book[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R8", int'(wb_count), 0, "wb_count in reset");
    rst_n = 1'b1;
    idle("R8", 2);
    // R1/R2: single constant op, then a float op landing 3 cycles later
    step("R1", 5'b00001, 0, 0, 0, 0, 0);
    idle("R2", 2);
    step("R2", 5'b00010, 0, 8, 0, 0, 0);
    idle("R2", 4);
    step("R2", 5'b00111, 2, 1, 3, 0, 0);
    idle("R2", 4);
    // R3: fill a future cycle to the cap, then try to add one more write
    step("R3", 5'b11111, 8, 8, 8, 8, 8);
    idle("R3", 1);
    step("R3", 5'b00001, 0, 0, 0, 0, 0);
    step("R7", 5'b00001, 1, 0, 0, 0, 0);
    idle("R7", 3);
    // R4/R6: divide busy window; rejected bundles book nothing
    step("R4", 5'b00001, 11, 0, 0, 0, 0);
    for (int k = 0; k < DIV_REC + 2; k++) step("R4", 5'b00011, 11, 0, 0, 0, 0);
    idle("R6", 3);
    step("R4", 5'b00001, 11, 0, 0, 0, 0);
    step("R6", 5'b00011, 11, 1, 0, 0, 0);
    idle("R6", 2);
    // collide: divide busy and write cap in the same bundle
    step("R3", 5'b11111, 9, 9, 9, 9, 9);
    step("R6", 5'b00011, 11, 0, 0, 0, 0);
    step("R3", 5'b00011, 0, 11, 0, 0, 0);
    idle("R6", DIV_REC + 2);
    // R5: two divide ops in one bundle
    step("R5", 5'b00011, 11, 11, 0, 0, 0);
    step("R5", 5'b10101, 11, 0, 11, 0, 11);
    idle("R5", 2);
    step("R1", 5'b00000, 11, 11, 0, 0, 0);
    // random phase
    for (int k = 0; k < 4000; k++) begin
      int r [NSLOT];
      logic [NSLOT-1:0] v;
      v = NSLOT'($urandom);
      if ($urandom_range(0, 3) == 0) v = '1;
      for (int s = 0; s < NSLOT; s++)
        r[s] = ($urandom_range(0, 5) == 0) ? 11 : int'($urandom_range(0, 15));
      step("R1", v, r[0], r[1], r[2], r[3], r[4]);
    end
    chk("R4", int'(n_acc_div > 2), 1, "divide ops accepted");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog run hung actual=%0d expected=%0d", cyc, 4200);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule